// File: doc/BRIEF.md
# Recursive Multi-Exposure Pixel Estimator

This block merges a burst of captures of one scene, taken with exposure times that double from one capture to the next, into a single high-dynamic-range value per pixel. Samples arrive as a stream. Each sample carries a capture index, a pixel address and an unsigned pixel value. For each pixel the block keeps a small recursive state: a weighted accumulator, a weight sum, the last accepted sample and a frozen flag. The size of this state does not depend on how many captures the burst contains.

Each accepted sample is first brought to the scale of the longest exposure by a left shift. It is then added to the accumulator with a weight that grows with the capture index, and its weight is added to the weight sum. A pixel stops updating, and keeps its estimate, in two cases:
- a sample reaches the saturation threshold;
- a sample departs from the current estimate by more than the motion tolerance.

When the burst is over, a read command streams out one value per pixel in address order. The value is either the weighted mean or, in the fallback mode, the last accepted sample scaled up to the longest exposure.

A burst-start pulse clears all pixel state. Within a burst, the samples of each pixel must arrive in increasing capture order, and the capture index must be below the configured capture count.

Top module: `hdr_burst_estimator`

## Requirements
- R1: After reset, out_valid is low and a read streams the value 0 for every pixel.
- R2: A sample with capture index k is normalised as val << (NCAP-1-k) and weighted by k+1. With lsbs_mode=0 the output is floor(sum of weight*normalised / sum of weights) over the accepted samples.
- R3: A sample with val >= sat_thr is excluded and freezes its pixel. Every later sample to a frozen pixel has no effect until the next burst start.
- R4: For a pixel with at least one accepted sample, let A be the accumulator, W the weight sum and s = NCAP-1-k. A sample is a motion event, and freezes the pixel without being accumulated, when |norm*W - A| > (mot_tol << s)*W. Equality is accepted.
- R5: The first accepted sample initialises the estimate. A pixel frozen with no accepted sample outputs full scale, which is all ones in OUT_W = PIX_W+NCAP-1 bits (8191 by default). A pixel that received no sample outputs 0.
- R6: With lsbs_mode=1 the output is the last accepted sample shifted left by NCAP-1 minus that sample's capture index.
- R7: A burst_start pulse clears the state of every pixel. A sample offered in the same cycle is dropped.
- R8: When read_start is sampled, out_valid rises two cycles later. It then stays high for NPIX consecutive cycles, with out_addr running 0 to NPIX-1. Reading does not alter pixel state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| burst_start | input | 1 | Clears all pixel state |
| smp_valid | input | 1 | Sample strobe |
| smp_cap | input | CAP_W | Capture index of the sample |
| smp_addr | input | ADDR_W | Pixel address of the sample |
| smp_val | input | PIX_W | Sample value |
| sat_thr | input | PIX_W | Saturation threshold |
| mot_tol | input | PIX_W | Motion tolerance in sample units |
| lsbs_mode | input | 1 | 1 selects the last-valid-sample output |
| read_start | input | 1 | Starts the output stream |
| out_valid | output | 1 | Output beat valid |
| out_addr | output | ADDR_W | Pixel address of the output beat |
| out_value | output | OUT_W | High-dynamic-range pixel value |

## Verification
Faults in the internal state only become visible at the ports when the pixels are streamed out after a burst:
- A frozen flag that is lost or set by mistake shows up as a mean that has drifted toward later samples, or stopped early.
- A wrong accumulator or weight sum shows up as a quotient that is off.
- A wrong last index shows up in the fallback mode as a value scaled by the wrong power of two.

Each stimulus pixel is therefore built so that exactly one rule decides its final value, and the tolerance edge is tested both at equality and one count past it. Sequencing faults in the readout show up within the first beat as a wrong latency or a wrong address.

// File: rtl/hdr_pkg.sv
package hdr_pkg;
  parameter int PIX_W  = 8;
  parameter int NCAP   = 6;
  localparam int CAP_W  = (NCAP > 1) ? $clog2(NCAP) : 1;
  localparam int OUT_W  = PIX_W + NCAP - 1;
  localparam int WS_MAX = NCAP * (NCAP + 1) / 2;
  localparam int WS_W   = $clog2(WS_MAX + 1);
  localparam int ACC_W  = OUT_W + WS_W;

  typedef struct packed {
    logic             frozen;
    logic             has;
    logic [CAP_W-1:0] last_cap;
    logic [PIX_W-1:0] last_val;
    logic [WS_W-1:0]  wsum;
    logic [ACC_W-1:0] acc;
  } px_state_t;

  localparam int ST_W = $bits(px_state_t);
endpackage

// File: rtl/hdr_px_update.sv
module hdr_px_update
  import hdr_pkg::*;
(
  input  px_state_t        cur,
  input  logic [CAP_W-1:0] cap,
  input  logic [PIX_W-1:0] val,
  input  logic [PIX_W-1:0] sat_thr,
  input  logic [PIX_W-1:0] mot_tol,
  output px_state_t        nxt
);
  logic [CAP_W-1:0] shamt;
  logic [WS_W-1:0]  wgt;
  logic [OUT_W-1:0] norm;
  logic [OUT_W-1:0] tol_n;
  logic [ACC_W-1:0] wn;
  logic [ACC_W-1:0] lhs;
  logic [ACC_W-1:0] diff;
  logic [ACC_W-1:0] bound;
  logic             sat;
  logic             motion;

  always_comb begin
    shamt  = CAP_W'(NCAP - 1) - cap;
    wgt    = WS_W'(cap) + WS_W'(1);
    norm   = OUT_W'(val) << shamt;
    tol_n  = OUT_W'(mot_tol) << shamt;
    wn     = ACC_W'(norm) * ACC_W'(wgt);
    lhs    = ACC_W'(norm) * ACC_W'(cur.wsum);
    diff   = (lhs >= cur.acc) ? (lhs - cur.acc) : (cur.acc - lhs);
    bound  = ACC_W'(tol_n) * ACC_W'(cur.wsum);
    sat    = (val >= sat_thr);
    motion = cur.has && (diff > bound);

    nxt = cur;
    if (!cur.frozen) begin
      if (sat || motion) begin
        nxt.frozen = 1'b1;
      end else begin
        nxt.has      = 1'b1;
        nxt.last_cap = cap;
        nxt.last_val = val;
        nxt.wsum     = cur.has ? (cur.wsum + wgt) : wgt;
        nxt.acc      = cur.has ? (cur.acc + wn) : wn;
      end
    end
  end
endmodule

// File: rtl/hdr_state_mem.sv
module hdr_state_mem
  import hdr_pkg::*;
#(
  parameter int NPIX   = 16,
  parameter int ADDR_W = $clog2(NPIX)
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              clr,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  px_state_t         wdata,
  input  logic [ADDR_W-1:0] raddr_a,
  output px_state_t         rdata_a,
  input  logic [ADDR_W-1:0] raddr_b,
  output px_state_t         rdata_b,
  output logic [NPIX-1:0]   frozen_vec
);
  px_state_t ent_q [NPIX];

  for (genvar i = 0; i < NPIX; i++) begin : g_ent
    logic      en;
    px_state_t d;

    always_comb begin
      en = clr || (we && (waddr == ADDR_W'(i)));
      d  = clr ? px_state_t'('0) : wdata;
    end

    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni)  ent_q[i] <= px_state_t'('0);
      else if (en)  ent_q[i] <= d;
    end

    assign frozen_vec[i] = ent_q[i].frozen;
  end

  assign rdata_a = ent_q[raddr_a];
  assign rdata_b = ent_q[raddr_b];
endmodule

// File: rtl/hdr_readout.sv
module hdr_readout
  import hdr_pkg::*;
#(
  parameter int NPIX   = 16,
  parameter int ADDR_W = $clog2(NPIX)
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              read_start,
  input  logic              lsbs_mode,
  output logic [ADDR_W-1:0] rd_addr,
  input  px_state_t         rd_state,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_addr,
  output logic [OUT_W-1:0]  out_value
);
  logic              act_q, act_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic [OUT_W-1:0]  val_d;
  logic [ACC_W-1:0]  quot;
  logic [CAP_W-1:0]  lshift;

  always_comb begin
    act_d = act_q;
    ptr_d = ptr_q;
    if (read_start) begin
      act_d = 1'b1;
      ptr_d = '0;
    end else if (act_q) begin
      if (ptr_q == ADDR_W'(NPIX - 1)) act_d = 1'b0;
      else                           ptr_d = ptr_q + ADDR_W'(1);
    end
  end

  always_comb begin
    lshift = CAP_W'(NCAP - 1) - rd_state.last_cap;
    quot   = (rd_state.wsum != '0) ? (rd_state.acc / ACC_W'(rd_state.wsum)) : '0;
    if (rd_state.has)
      val_d = lsbs_mode ? (OUT_W'(rd_state.last_val) << lshift) : quot[OUT_W-1:0];
    else
      val_d = rd_state.frozen ? '1 : '0;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q     <= 1'b0;
      ptr_q     <= '0;
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_value <= '0;
    end else begin
      act_q     <= act_d;
      ptr_q     <= ptr_d;
      out_valid <= act_q;
      out_addr  <= ptr_q;
      out_value <= val_d;
    end
  end

  assign rd_addr = ptr_q;
endmodule

// File: rtl/hdr_burst_estimator.sv
module hdr_burst_estimator
  import hdr_pkg::*;
#(
  parameter  int NPIX   = 16,
  localparam int ADDR_W = $clog2(NPIX)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              burst_start,
  input  logic              smp_valid,
  input  logic [CAP_W-1:0]  smp_cap,
  input  logic [ADDR_W-1:0] smp_addr,
  input  logic [PIX_W-1:0]  smp_val,
  input  logic [PIX_W-1:0]  sat_thr,
  input  logic [PIX_W-1:0]  mot_tol,
  input  logic              lsbs_mode,
  input  logic              read_start,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_addr,
  output logic [OUT_W-1:0]  out_value
);
  logic [1:0]        rst_sync_q;
  logic              rst_ni;
  logic              wr_en;
  px_state_t         cur_st;
  px_state_t         nxt_st;
  px_state_t         rd_st;
  logic [ADDR_W-1:0] rd_addr;
  logic [NPIX-1:0]   pix_frozen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  assign wr_en = smp_valid && !burst_start;

  hdr_state_mem #(.NPIX(NPIX), .ADDR_W(ADDR_W)) u_mem (
    .clk        (clk),
    .rst_ni     (rst_ni),
    .clr        (burst_start),
    .we         (wr_en),
    .waddr      (smp_addr),
    .wdata      (nxt_st),
    .raddr_a    (smp_addr),
    .rdata_a    (cur_st),
    .raddr_b    (rd_addr),
    .rdata_b    (rd_st),
    .frozen_vec (pix_frozen)
  );

  hdr_px_update u_upd (
    .cur     (cur_st),
    .cap     (smp_cap),
    .val     (smp_val),
    .sat_thr (sat_thr),
    .mot_tol (mot_tol),
    .nxt     (nxt_st)
  );

  hdr_readout #(.NPIX(NPIX), .ADDR_W(ADDR_W)) u_rd (
    .clk        (clk),
    .rst_ni     (rst_ni),
    .read_start (read_start),
    .lsbs_mode  (lsbs_mode),
    .rd_addr    (rd_addr),
    .rd_state   (rd_st),
    .out_valid  (out_valid),
    .out_addr   (out_addr),
    .out_value  (out_value)
  );
endmodule

// File: rtl/hdr_burst_estimator_chk.sv
module hdr_burst_estimator_chk #(
  parameter  int NPIX   = 16,
  localparam int ADDR_W = $clog2(NPIX)
) (
  input logic              clk,
  input logic              rst_ni,
  input logic              burst_start,
  input logic              read_start,
  input logic              out_valid,
  input logic [ADDR_W-1:0] out_addr,
  input logic [NPIX-1:0]   pix_frozen
);
  p_start_lat_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    read_start |-> ##2 out_valid);

  p_first_addr_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(out_valid) |-> out_addr == '0);

  p_addr_step_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    out_valid && $past(out_valid) && !$past(read_start, 2) |->
      out_addr == $past(out_addr) + ADDR_W'(1));

  p_run_len_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    out_valid && out_addr != ADDR_W'(NPIX - 1) |=> out_valid);

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    burst_start |=> pix_frozen == '0);

  for (genvar i = 0; i < NPIX; i++) begin : g_px
    p_frozen_sticky_r3: assert property (@(posedge clk) disable iff (!rst_ni)
      pix_frozen[i] && !burst_start |=> pix_frozen[i]);
  end
endmodule

bind hdr_burst_estimator hdr_burst_estimator_chk #(.NPIX(NPIX)) u_chk (.*);

// File: tb/hdr_burst_estimator_tb.sv
`timescale 1ns/1ps
module hdr_burst_estimator_tb;
  import hdr_pkg::*;
  localparam int NPIX   = 16;
  localparam int ADDR_W = $clog2(NPIX);
  localparam int NROW   = 9;
  localparam int FULL   = (1 << OUT_W) - 1;

  // per row: sample for capture 0..5, expected mean, expected last-valid value
  localparam int TBL [NROW][8] = '{
    '{  3,   6,  12,  24,  48,  96,   96,   96},
    '{ 20,  40,  80, 160, 255, 255,  640,  640},
    '{255, 255, 255, 255, 255, 255, FULL, FULL},
    '{  0,   0,   0,   0,   0,   0,    0,    0},
    '{ 10,  21,  40,  81, 160, 250,  323,  320},
    '{ 10,  20,  40, 120, 240, 240,  320,  320},
    '{100, 208, 250,  10,  10,  10, 3285, 3328},
    '{100, 209,  10,  10,  10,  10, 3200, 3200},
    '{249, 250,  10,  10,  10,  10, 7968, 7968}
  };

  logic              clk;
  logic              rst_n;
  logic              burst_start;
  logic              smp_valid;
  logic [CAP_W-1:0]  smp_cap;
  logic [ADDR_W-1:0] smp_addr;
  logic [PIX_W-1:0]  smp_val;
  logic [PIX_W-1:0]  sat_thr;
  logic [PIX_W-1:0]  mot_tol;
  logic              lsbs_mode;
  logic              read_start;
  logic              out_valid;
  logic [ADDR_W-1:0] out_addr;
  logic [OUT_W-1:0]  out_value;

  int checks = 0;
  int errors = 0;
  int expv [NPIX];
  string tagv [NPIX];

  hdr_burst_estimator #(.NPIX(NPIX)) u_dut (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic pulse_burst();
    burst_start = 1'b1;
    @(negedge clk);
    burst_start = 1'b0;
  endtask

  task automatic send(input int addr, input int cap, input int val);
    smp_valid = 1'b1;
    smp_addr  = ADDR_W'(addr);
    smp_cap   = CAP_W'(cap);
    smp_val   = PIX_W'(val);
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic read_all(input logic mode);
    lsbs_mode  = mode;
    read_start = 1'b1;
    @(negedge clk);
    read_start = 1'b0;
    chk("R8", int'(out_valid), 0, "valid one cycle after start");
    @(negedge clk);
    for (int i = 0; i < NPIX; i++) begin
      chk("R8", int'(out_valid), 1, $sformatf("valid beat %0d", i));
      chk("R8", int'(out_addr), i, "beat address");
      chk(tagv[i], int'(out_value), expv[i], $sformatf("pixel %0d value mode %0d", i, mode));
      @(negedge clk);
    end
    chk("R8", int'(out_valid), 0, "valid after last beat");
  endtask

  function automatic string row_tag(input int p);
    case (p)
      1, 8:    return "R3";
      2:       return "R5";
      5, 6, 7: return "R4";
      default: return "R2";
    endcase
  endfunction

  initial begin
    rst_n = 1'b0; burst_start = 1'b0; smp_valid = 1'b0; smp_cap = '0;
    smp_addr = '0; smp_val = '0; sat_thr = 8'd250; mot_tol = 8'd8;
    lsbs_mode = 1'b0; read_start = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    chk("R1", int'(out_valid), 0, "out_valid after reset");
    for (int i = 0; i < NPIX; i++) begin expv[i] = 0; tagv[i] = "R1"; end
    read_all(1'b0);

    // burst: captures interleaved across pixels, increasing capture index
    pulse_burst();
    for (int c = 0; c < NCAP; c++)
      for (int p = 0; p < NROW; p++)
        send(p, c, TBL[p][c]);

    for (int i = 0; i < NPIX; i++) begin
      expv[i] = (i < NROW) ? TBL[i][6] : 0;
      tagv[i] = (i < NROW) ? row_tag(i) : "R5";
    end
    read_all(1'b0);

    for (int i = 0; i < NPIX; i++) begin
      expv[i] = (i < NROW) ? TBL[i][7] : 0;
      tagv[i] = (i < NROW) ? "R6" : "R5";
    end
    read_all(1'b1);

    // new burst clears everything; sample coincident with burst_start is dropped
    smp_valid = 1'b1; smp_addr = 4'd3; smp_cap = 3'd5; smp_val = 8'd99;
    pulse_burst();
    smp_valid = 1'b0;
    send(0, 5, 7);
    for (int i = 0; i < NPIX; i++) begin expv[i] = 0; tagv[i] = "R7"; end
    expv[0] = 7;
    read_all(1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule